// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory device from reset to a usable state. A start pulse in the idle state launches a fixed program of fourteen steps. Each step drives one command (command code, bank field, address payload, and a one-cycle valid strobe) onto a simple command interface. A per-step wait in memory-clock cycles follows each command. The mode-register contents come from four configuration inputs. The block forces the DLL-reset bit and the off-chip-driver calibration field itself, in the steps that need them.

After the wait of the last step, the block raises a sticky init-complete flag. From then on it accepts the controller-enable input. Once enabled, it waits for the delay-line calibration done input before it raises ready.

States:
- `ST_IDLE`: waits for start.
- `ST_ISSUE`: drives one command.
- `ST_WAIT`: counts the wait of the current step.
- `ST_INITDONE`: waits for enable.
- `ST_CALWAIT`: waits for calibration done.
- `ST_READY`: terminal.

Transitions:
- `ST_IDLE` to `ST_ISSUE` on start.
- `ST_ISSUE` to `ST_WAIT` always.
- `ST_WAIT` to `ST_ISSUE` when the wait expires and a step remains.
- `ST_WAIT` to `ST_INITDONE` when the wait of step 13 expires.
- `ST_INITDONE` to `ST_CALWAIT` on enable.
- `ST_CALWAIT` to `ST_READY` on calibration done.
- Synchronous reset returns any state to `ST_IDLE`.

Top module: `ddr2_init_seq`

## Requirements
- R1: A synchronous reset puts the block in idle. After reset, cmd_valid is 0, cmd_code is NOP (3'b111), cmd_bank and cmd_addr are 0, and init_done and ready are 0. While idle and without start, no command is issued.
- R2: When start is sampled high in idle, the first command (NOP, bank 0, address 0) is driven with cmd_valid high in the next cycle.
- R3: The commands come in this order, with codes MRS=3'b000, REF=3'b001, PRE=3'b010, NOP=3'b111:
  - step 0: NOP
  - step 1: PRE
  - steps 2, 3, 4: MRS to bank 2, bank 3, then bank 1
  - step 5: MRS to bank 0
  - step 6: PRE
  - steps 7 to 10: four REF
  - step 11: MRS to bank 0
  - steps 12 and 13: MRS to bank 1
  
  Outside a command cycle, cmd_code is NOP.
- R4: Between a command and the next one there are exactly W idle cycles (cmd_valid low), where W is:
  - step 0: 106
  - steps 1 and 6: 4
  - steps 2, 3, 4, 11, 12 and 13: 2
  - step 5: 200
  - steps 7 to 10: 25
- R5: The payloads are as follows:
  - Precharge: address with only bit 10 set.
  - REF and NOP: address 0.
  - Step 2: cfg_emr2.
  - Step 3: cfg_emr3.
  - Steps 4 and 13: cfg_emr with bits 9:7 cleared.
  - Step 12: cfg_emr with bits 9:7 set.
  - Step 5: cfg_mr with bit 8 set.
  - Step 11: cfg_mr with bit 8 cleared.
  - All non-MRS commands carry bank 0.
- R6: init_done rises in the cycle just after the wait of step 13 expires. It then stays high until reset.
- R7: ctl_enable has no effect before init_done is high. Ready cannot rise earlier than two cycles after init_done rises, even if enable and calibration done are held high all along.
- R8: Once enabled, ready stays low while dlcal_done is low. Ready rises in the cycle after dlcal_done is sampled high in the calibration-wait state, and stays high until reset.
- R9: A start pulse while a sequence runs, or after it has ended, is ignored: command timing and content are unchanged and no command is issued.
- R10: cmd_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the init program when idle |
| cfg_mr | input | AW | Base mode-register payload |
| cfg_emr | input | AW | Base extended mode-register payload |
| cfg_emr2 | input | AW | Extended mode register 2 payload |
| cfg_emr3 | input | AW | Extended mode register 3 payload |
| ctl_enable | input | 1 | Controller enable, honoured only after init |
| dlcal_done | input | 1 | Delay-line calibration complete |
| cmd_code | output | 3 | Command code (MRS/REF/PRE/NOP) |
| cmd_bank | output | 2 | Bank-select / mode-register select |
| cmd_addr | output | AW | Address / mode payload |
| cmd_valid | output | 1 | One-cycle command strobe |
| init_done | output | 1 | Init program complete (sticky) |
| ready | output | 1 | Enabled and calibrated |

## Verification
The in-RTL properties check on every cycle that:
- strobes never come back to back;
- the NOP code holds outside command cycles;
- init_done is sticky;
- ready implies a prior init_done and a sampled calibration done;
- the wait counter steps down one per cycle.

The bench scenarios show the rest:
- the exact order and payloads of the fourteen commands;
- the exact spacing of each step;
- that early enable and stray start pulses change nothing;
- the latency from enable and calibration done to ready.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_INITDONE,
        ST_CALWAIT,
        ST_READY
    } seq_state_e;

    localparam int NUM_STEPS = 14;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int BANK_W    = 2;

endpackage

// File: rtl/ddr2_init_steps.sv
module ddr2_init_steps
    import ddr2_init_pkg::*;
#(
    parameter int AW     = 14,
    parameter int WAIT_W = 8,
    parameter int T_NOP  = 106,
    parameter int T_RP   = 4,
    parameter int T_MRD  = 2,
    parameter int T_DLL  = 200,
    parameter int T_RFC  = 25
) (
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     cfg_mr,
    input  logic [AW-1:0]     cfg_emr,
    input  logic [AW-1:0]     cfg_emr2,
    input  logic [AW-1:0]     cfg_emr3,
    output ddr_cmd_e          code,
    output logic [BANK_W-1:0] bank,
    output logic [AW-1:0]     addr,
    output logic [WAIT_W-1:0] wait_cyc
);

    localparam logic [AW-1:0] PRE_ALL  = AW'(1) << 10;
    localparam logic [AW-1:0] DLL_RST  = AW'(1) << 8;
    localparam logic [AW-1:0] OCD_MASK = AW'(7) << 7;

    logic [AW-1:0] emr_base;
    assign emr_base = cfg_emr & ~OCD_MASK;

    always_comb begin
        code     = CMD_NOP;
        bank     = '0;
        addr     = '0;
        wait_cyc = WAIT_W'(T_MRD);
        unique case (step)
            4'd0:  begin code = CMD_NOP; wait_cyc = WAIT_W'(T_NOP); end
            4'd1:  begin code = CMD_PRE; addr = PRE_ALL; wait_cyc = WAIT_W'(T_RP); end
            4'd2:  begin code = CMD_MRS; bank = 2'd2; addr = cfg_emr2; end
            4'd3:  begin code = CMD_MRS; bank = 2'd3; addr = cfg_emr3; end
            4'd4:  begin code = CMD_MRS; bank = 2'd1; addr = emr_base; end
            4'd5:  begin code = CMD_MRS; addr = cfg_mr | DLL_RST; wait_cyc = WAIT_W'(T_DLL); end
            4'd6:  begin code = CMD_PRE; addr = PRE_ALL; wait_cyc = WAIT_W'(T_RP); end
            4'd7, 4'd8, 4'd9, 4'd10:
                   begin code = CMD_REF; wait_cyc = WAIT_W'(T_RFC); end
            4'd11: begin code = CMD_MRS; addr = cfg_mr & ~DLL_RST; end
            4'd12: begin code = CMD_MRS; bank = 2'd1; addr = cfg_emr | OCD_MASK; end
            4'd13: begin code = CMD_MRS; bank = 2'd1; addr = emr_base; end
            default: begin code = CMD_NOP; end
        endcase
    end

endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              last
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == WAIT_W'(1));

    // R4: every loaded wait is at least one cycle
    a_r4_nonzero_load: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    // R4: a running count drops by exactly one per cycle
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int AW    = 14,
    parameter int T_NOP = 106,
    parameter int T_RP  = 4,
    parameter int T_MRD = 2,
    parameter int T_DLL = 200,
    parameter int T_RFC = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_mr,
    input  logic [AW-1:0] cfg_emr,
    input  logic [AW-1:0] cfg_emr2,
    input  logic [AW-1:0] cfg_emr3,
    input  logic          ctl_enable,
    input  logic          dlcal_done,
    output logic [2:0]    cmd_code,
    output logic [1:0]    cmd_bank,
    output logic [AW-1:0] cmd_addr,
    output logic          cmd_valid,
    output logic          init_done,
    output logic          ready
);

    localparam int MAX_A  = (T_NOP > T_DLL) ? T_NOP : T_DLL;
    localparam int MAX_B  = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int MAX_C  = (MAX_B > T_MRD) ? MAX_B : T_MRD;
    localparam int MAX_W  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int WAIT_W = $clog2(MAX_W + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q;
    ddr_cmd_e          st_code;
    logic [BANK_W-1:0] st_bank;
    logic [AW-1:0]     st_addr;
    logic [WAIT_W-1:0] st_wait;
    logic              wait_last;

    ddr2_init_steps #(
        .AW(AW), .WAIT_W(WAIT_W), .T_NOP(T_NOP), .T_RP(T_RP),
        .T_MRD(T_MRD), .T_DLL(T_DLL), .T_RFC(T_RFC)
    ) u_steps (
        .step(step_q), .cfg_mr(cfg_mr), .cfg_emr(cfg_emr),
        .cfg_emr2(cfg_emr2), .cfg_emr3(cfg_emr3),
        .code(st_code), .bank(st_bank), .addr(st_addr), .wait_cyc(st_wait)
    );

    ddr2_init_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk(clk), .rst(rst), .load(state_q == ST_ISSUE),
        .load_val(st_wait), .last(wait_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_ISSUE;
            ST_ISSUE:    state_d = ST_WAIT;
            ST_WAIT:     if (wait_last)
                             state_d = (step_q == LAST_STEP) ? ST_INITDONE : ST_ISSUE;
            ST_INITDONE: if (ctl_enable) state_d = ST_CALWAIT;
            ST_CALWAIT:  if (dlcal_done) state_d = ST_READY;
            ST_READY:    state_d = ST_READY;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                step_q <= '0;
            else if (state_q == ST_WAIT && wait_last && step_q != LAST_STEP)
                step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_code  = CMD_NOP;
        cmd_bank  = '0;
        cmd_addr  = '0;
        init_done = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_code  = st_code;
                cmd_bank  = st_bank;
                cmd_addr  = st_addr;
            end
            ST_INITDONE, ST_CALWAIT: init_done = 1'b1;
            ST_READY: begin
                init_done = 1'b1;
                ready     = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: reset leaves the command bus quiet and the flags low
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !init_done && !ready));

    // R10: strobes never come back to back
    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R3: outside a command cycle the code is NOP
    a_r3_nop_outside: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_code == 3'b111));

    // R6: init-complete is sticky
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R7: ready never appears without a prior init-complete
    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(init_done));

    // R8: ready rises only after calibration done was sampled
    a_r8_ready_needs_cal: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(dlcal_done));

endmodule

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
module sim_ddr2_init_seq;

    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_mr = '0, cfg_emr = '0, cfg_emr2 = '0, cfg_emr3 = '0;
    logic          ctl_enable = 1'b0;
    logic          dlcal_done = 1'b0;
    logic [2:0]    cmd_code;
    logic [1:0]    cmd_bank;
    logic [AW-1:0] cmd_addr;
    logic          cmd_valid, init_done, ready;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ddr2_init_seq #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_mr(cfg_mr), .cfg_emr(cfg_emr), .cfg_emr2(cfg_emr2), .cfg_emr3(cfg_emr3),
        .ctl_enable(ctl_enable), .dlcal_done(dlcal_done),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_valid(cmd_valid), .init_done(init_done), .ready(ready)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input int i);
        case (i)
            0:                        return 106;
            1, 6:                     return 4;
            5:                        return 200;
            7, 8, 9, 10:              return 25;
            default:                  return 2;
        endcase
    endfunction

    function automatic logic [18:0] exp_cmd(input int i, input logic [AW-1:0] mr,
        input logic [AW-1:0] emr, input logic [AW-1:0] e2, input logic [AW-1:0] e3);
        logic [AW-1:0] ocd = 14'h0380;
        logic [AW-1:0] dll = 14'h0100;
        case (i)
            0:            return {3'b111, 2'd0, 14'h0};
            1, 6:         return {3'b010, 2'd0, 14'h0400};
            2:            return {3'b000, 2'd2, e2};
            3:            return {3'b000, 2'd3, e3};
            4, 13:        return {3'b000, 2'd1, emr & ~ocd};
            5:            return {3'b000, 2'd0, mr | dll};
            7, 8, 9, 10:  return {3'b001, 2'd0, 14'h0};
            11:           return {3'b000, 2'd0, mr & ~dll};
            default:      return {3'b000, 2'd1, emr | ocd};
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; ctl_enable = 1'b0; dlcal_done = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
        check(!cmd_valid && cmd_code == 3'b111 && cmd_bank == 0 && cmd_addr == 0
              && !init_done && !ready, "R1 reset state",
              {cmd_valid, cmd_code, init_done, ready}, 32'h1c);
    endtask

    task automatic run_seq(input bit early, input bit poke, input int en_dly,
                           input int cal_dly);
        logic [18:0] got;
        int quiet_bad;
        cfg_mr   = AW'($urandom);
        cfg_emr  = AW'($urandom);
        cfg_emr2 = AW'($urandom);
        cfg_emr3 = AW'($urandom);
        ctl_enable = early;
        dlcal_done = early;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 14; i++) begin
            got = {cmd_code, cmd_bank, cmd_addr};
            check(cmd_valid, "R2 R4 strobe at step", {28'd0, 4'(i)}, 32'd1);
            check(got == exp_cmd(i, cfg_mr, cfg_emr, cfg_emr2, cfg_emr3),
                  (i == 0) ? "R2 first command" : "R3 R5 command content",
                  {13'd0, got}, {13'd0, exp_cmd(i, cfg_mr, cfg_emr, cfg_emr2, cfg_emr3)});
            quiet_bad = 0;
            for (int k = 1; k <= exp_wait(i); k++) begin
                start = (poke && k == 1);
                tick();
                if (cmd_valid || init_done || ready) quiet_bad++;
            end
            start = 1'b0;
            check(quiet_bad == 0, poke ? "R4 R9 R10 quiet gap" : "R4 R10 quiet gap",
                  quiet_bad, 0);
            tick();
        end
        check(init_done && !ready && !cmd_valid, "R6 init_done after last wait",
              {init_done, ready, cmd_valid}, 32'h4);
        if (early) begin
            tick();
            check(init_done && !ready, "R7 no early ready", ready, 0);
            tick();
            check(ready, "R7 R8 ready two cycles after init_done", ready, 1);
        end else begin
            quiet_bad = 0;
            for (int k = 0; k < en_dly; k++) begin
                tick();
                if (ready || !init_done) quiet_bad++;
            end
            check(quiet_bad == 0, "R6 R8 hold without enable", quiet_bad, 0);
            ctl_enable = 1'b1;
            quiet_bad = 0;
            for (int k = 0; k < cal_dly; k++) begin
                tick();
                if (ready) quiet_bad++;
            end
            check(quiet_bad == 0, "R8 hold without calibration", quiet_bad, 0);
            dlcal_done = 1'b1;
            tick();
            check(ready, "R8 ready after calibration", ready, 1);
        end
        start = 1'b1;
        tick();
        start = 1'b0;
        quiet_bad = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (cmd_valid || !ready || !init_done) quiet_bad++;
        end
        check(quiet_bad == 0, "R9 R8 start after ready ignored", quiet_bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int idle_bad;
        void'($urandom(32'd4242));
        tick();
        do_reset();
        idle_bad = 0;
        for (int k = 0; k < 30; k++) begin
            tick();
            if (cmd_valid || init_done) idle_bad++;
        end
        check(idle_bad == 0, "R1 idle without start", idle_bad, 0);

        run_seq(1'b1, 1'b0, 0, 1);
        do_reset();
        run_seq(1'b0, 1'b1, 3, 4);
        do_reset();
        for (int r = 0; r < 3; r++) begin
            run_seq(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 8),
                    1 + int'($urandom % 6));
            do_reset();
        end

        start = 1'b1; tick(); start = 1'b0;
        for (int k = 0; k < 150; k++) tick();
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check(!cmd_valid && cmd_code == 3'b111 && !init_done, "R1 reset mid-sequence",
              {cmd_valid, cmd_code, init_done}, 32'he);
        idle_bad = 0;
        for (int k = 0; k < 250; k++) begin
            tick();
            if (cmd_valid || init_done) idle_bad++;
        end
        check(idle_bad == 0, "R1 stays idle after reset", idle_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule